// File: doc/BRIEF.md
# Float-to-Signed-Integer Converter

This unit turns one IEEE-754 single-precision value into a signed two's-complement integer that is either 32 or 64 bits wide. The result follows processor semantics. A value that cannot be represented, and any NaN or infinity, raises an invalid flag. When that exception is masked, the unit returns the "integer indefinite" pattern, in which only the sign bit of the destination width is set. When a nonzero fraction is discarded, a precision flag reports it.

The rounding mode normally comes from a global two-bit control. A per-operation override replaces it only when the operand comes from a register and the override is enabled. The unit has one register stage. Operands presented before a rising clock edge produce their result, invalid flag and precision flag just after that edge. A synchronous active-high reset clears all three outputs.

Top module: `f2i_convert`

## Requirements
- R1: Only bits [31:0] of the source port are interpreted as the floating-point operand. Bits above 31 have no effect on any output.
- R2: The result is a 64-bit signed integer only when `mode64_i` and `size64_i` are both 1. Otherwise it is a 32-bit signed integer placed in `result_o[31:0]`, with `result_o[63:32]` zero. A 64-bit size request is ignored when `mode64_i` is 0.
- R3: Inexact values are rounded by the active mode, encoded as 00 nearest-even, 01 toward negative infinity, 10 toward positive infinity, 11 toward zero.
- R4: The active mode is `rc_ovr_i` when `src_reg_i` and `rc_ovr_en_i` are both 1. In every other case it is `rc_global_i`.
- R5: `invalid_o` is raised when the rounded value lies outside [-2^(w-1), 2^(w-1)-1] for destination width w. A value rounding to exactly -2^(w-1) is valid, and one rounding to +2^(w-1) is invalid.
- R6: With `inv_mask_i` = 1, an invalid conversion returns 2^(w-1): 0x0000000080000000 for 32 bits, 0x8000000000000000 for 64 bits.
- R7: With `inv_mask_i` = 0, an invalid conversion leaves `result_o` at its previous value, while the flags still update.
- R8: Exponent field all ones (a NaN of any kind, or infinity) always raises invalid and never raises precision.
- R9: `precision_o` is 1 exactly when nonzero fraction bits were discarded and the conversion is valid. This includes denormals that round to 0 or ±1.
- R10: Outputs appear one clock after the operand is sampled. A synchronous reset sets `result_o` to 0 and both flags to 0.
- R11: `invalid_o` and `precision_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | SRC_W (64) | Source; low 32 bits hold the single-precision operand |
| size64_i | input | 1 | Request 64-bit destination |
| mode64_i | input | 1 | 64-bit mode active |
| rc_global_i | input | 2 | Global rounding control |
| rc_ovr_i | input | 2 | Per-operation rounding override |
| rc_ovr_en_i | input | 1 | Override enable |
| src_reg_i | input | 1 | Operand comes from a register |
| inv_mask_i | input | 1 | Invalid exception masked |
| result_o | output | INT_W (64) | Signed integer result |
| invalid_o | output | 1 | Invalid flag |
| precision_o | output | 1 | Inexact flag |

## Verification
On every cycle the assertions check that the two flags are exclusive, and that reset clears the outputs. They also check that NaN and infinity operands always flag invalid, that a masked invalid result carries the indefinite pattern for the selected width, that an unmasked invalid holds the previous result, and that 32-bit results keep their upper half zero. Only the bench's sweep can show the rounding itself. It steps through every exponent, both signs, four rounding modes and four width settings with selected fraction patterns, so it covers ties to even, the asymmetric range bounds and denormals. The bench also shows that the mode source follows the register and override conditions, and that the upper source bits are ignored.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_DOWN    = 2'b01,
    RM_UP      = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;
endpackage

// File: rtl/f2i_unpack.sv
// Splits a binary floating-point word into sign, significand with hidden bit,
// unbiased exponent and a flag for the all-ones exponent (NaN / infinity).
module f2i_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int ESH_W = EXP_W + 2,
  localparam int FP_W = 1 + EXP_W + MAN_W,
  localparam int BIAS = (1 << (EXP_W - 1)) - 1
) (
  input  logic [FP_W-1:0]         fp_i,
  output logic                    sign_o,
  output logic                    special_o,
  output logic [MAN_W:0]          sig_o,
  output logic signed [ESH_W-1:0] uexp_o
);
  logic [EXP_W-1:0] efield;
  logic [ESH_W-1:0] eext;

  always_comb begin
    efield    = fp_i[FP_W-2:MAN_W];
    sign_o    = fp_i[FP_W-1];
    special_o = &efield;
    sig_o     = {|efield, fp_i[MAN_W-1:0]};
    // denormals share the exponent of the smallest normal
    eext      = (efield == '0) ? ESH_W'(1) : {{(ESH_W-EXP_W){1'b0}}, efield};
    uexp_o    = signed'(eext - ESH_W'(BIAS));
  end
endmodule

// File: rtl/f2i_round.sv
// Aligns the significand to an integer magnitude and rounds it by the mode.
module f2i_round
  import f2i_pkg::*;
#(
  parameter int MAN_W = 23,
  parameter int INT_W = 64,
  parameter int ESH_W = 10,
  localparam int SIG_W  = MAN_W + 1,
  localparam int PAD    = MAN_W + 3,
  localparam int WIDE_W = SIG_W + PAD,
  localparam int LSH_W  = $clog2(INT_W),
  localparam int RSH_W  = $clog2(PAD + 1)
) (
  input  logic                    sign_i,
  input  logic [MAN_W:0]          sig_i,
  input  logic signed [ESH_W-1:0] uexp_i,
  input  rmode_e                  rm_i,
  output logic [INT_W-1:0]        mag_o,
  output logic                    huge_o,
  output logic                    inexact_o
);
  logic [WIDE_W-1:0] wide;
  logic [SIG_W-1:0]  ipart;
  logic [LSH_W-1:0]  lamt;
  logic [RSH_W-1:0]  ramt;
  logic              guard, sticky, inc;
  int                ue;

  always_comb begin
    ue     = int'(uexp_i);
    huge_o = (ue > INT_W - 1);
    lamt   = '0;
    ramt   = '0;
    wide   = '0;
    ipart  = '0;
    guard  = 1'b0;
    sticky = 1'b0;
    inc    = 1'b0;
    mag_o  = '0;
    if (ue >= MAN_W) begin
      // integral value: pure left shift, no fraction lost
      lamt  = LSH_W'(ue - MAN_W);
      mag_o = {{(INT_W-SIG_W){1'b0}}, sig_i} << lamt;
    end else begin
      // clamping the shift keeps every shifted-out bit inside the sticky range
      ramt   = (MAN_W - ue > PAD) ? RSH_W'(PAD) : RSH_W'(MAN_W - ue);
      wide   = {sig_i, {PAD{1'b0}}} >> ramt;
      ipart  = wide[WIDE_W-1:PAD];
      guard  = wide[PAD-1];
      sticky = |wide[PAD-2:0];
      case (rm_i)
        RM_NEAREST: inc = guard & (sticky | ipart[0]);
        RM_DOWN:    inc = (guard | sticky) & sign_i;
        RM_UP:      inc = (guard | sticky) & ~sign_i;
        default:    inc = 1'b0;
      endcase
      mag_o = {{(INT_W-SIG_W){1'b0}}, ipart} + {{(INT_W-1){1'b0}}, inc};
    end
    inexact_o = guard | sticky;
  end
endmodule

// File: rtl/f2i_pack.sv
// Range check for the selected width, sign application, indefinite substitution.
module f2i_pack #(
  parameter int INT_W = 64,
  parameter int NAR_W = 32
) (
  input  logic             sign_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             huge_i,
  input  logic             special_i,
  input  logic             inexact_i,
  input  logic             wide_i,
  output logic [INT_W-1:0] value_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  localparam logic [INT_W-1:0] WIDE_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] NAR_MIN  = {{(INT_W-NAR_W){1'b0}}, 1'b1, {(NAR_W-1){1'b0}}};

  logic             pos_ok, neg_ok;
  logic [INT_W-1:0] twos;

  always_comb begin
    if (wide_i) begin
      pos_ok = ~mag_i[INT_W-1];
      neg_ok = pos_ok | (mag_i == WIDE_MIN);
    end else begin
      pos_ok = (mag_i[INT_W-1:NAR_W-1] == '0);
      neg_ok = pos_ok | (mag_i == NAR_MIN);
    end
    invalid_o = special_i | huge_i | (sign_i ? ~neg_ok : ~pos_ok);
    twos      = sign_i ? (~mag_i + INT_W'(1)) : mag_i;
    if (invalid_o)   value_o = wide_i ? WIDE_MIN : NAR_MIN;
    else if (wide_i) value_o = twos;
    else             value_o = {{(INT_W-NAR_W){1'b0}}, twos[NAR_W-1:0]};
    inexact_o = inexact_i & ~invalid_o;
  end
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
  import f2i_pkg::*;
#(
  parameter int SRC_W = 64,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 64,
  parameter int NAR_W = 32,
  localparam int FP_W  = 1 + EXP_W + MAN_W,
  localparam int ESH_W = EXP_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic             size64_i,
  input  logic             mode64_i,
  input  logic [1:0]       rc_global_i,
  input  logic [1:0]       rc_ovr_i,
  input  logic             rc_ovr_en_i,
  input  logic             src_reg_i,
  input  logic             inv_mask_i,
  output logic [INT_W-1:0] result_o,
  output logic             invalid_o,
  output logic             precision_o
);
  logic                    f_sign, f_special, r_huge, r_inexact, wide_sel;
  logic [MAN_W:0]          f_sig;
  logic signed [ESH_W-1:0] f_uexp;
  logic [INT_W-1:0]        r_mag, p_value;
  logic                    p_invalid, p_inexact;
  rmode_e                  rm_act;

  generate
    if (SRC_W > FP_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^src_i[SRC_W-1:FP_W];
    end
  endgenerate

  assign rm_act   = rmode_e'((src_reg_i & rc_ovr_en_i) ? rc_ovr_i : rc_global_i);
  assign wide_sel = mode64_i & size64_i;

  f2i_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .ESH_W(ESH_W)) u_unpack (
    .fp_i(src_i[FP_W-1:0]), .sign_o(f_sign), .special_o(f_special),
    .sig_o(f_sig), .uexp_o(f_uexp));

  f2i_round #(.MAN_W(MAN_W), .INT_W(INT_W), .ESH_W(ESH_W)) u_round (
    .sign_i(f_sign), .sig_i(f_sig), .uexp_i(f_uexp), .rm_i(rm_act),
    .mag_o(r_mag), .huge_o(r_huge), .inexact_o(r_inexact));

  f2i_pack #(.INT_W(INT_W), .NAR_W(NAR_W)) u_pack (
    .sign_i(f_sign), .mag_i(r_mag), .huge_i(r_huge), .special_i(f_special),
    .inexact_i(r_inexact), .wide_i(wide_sel), .value_o(p_value),
    .invalid_o(p_invalid), .inexact_o(p_inexact));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      result_o    <= '0;
      invalid_o   <= 1'b0;
      precision_o <= 1'b0;
    end else begin
      invalid_o   <= p_invalid;
      precision_o <= p_inexact;
      if (!(p_invalid && !inv_mask_i)) result_o <= p_value;
    end
  end
endmodule

// File: rtl/f2i_convert_chk.sv
module f2i_convert_chk #(
  parameter int SRC_W = 64,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 64,
  parameter int NAR_W = 32
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [SRC_W-1:0] src_i,
  input logic             size64_i,
  input logic             mode64_i,
  input logic             inv_mask_i,
  input logic [INT_W-1:0] result_o,
  input logic             invalid_o,
  input logic             precision_o
);
  localparam int FP_W = 1 + EXP_W + MAN_W;
  localparam logic [INT_W-1:0] WIDE_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] NAR_MIN  = {{(INT_W-NAR_W){1'b0}}, 1'b1, {(NAR_W-1){1'b0}}};

  assert_flags_exclusive_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    !(invalid_o && precision_o));

  assert_reset_clear_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (result_o == '0 && !invalid_o && !precision_o));

  assert_special_invalid_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(&src_i[FP_W-2:MAN_W])) |-> (invalid_o && !precision_o));

  assert_indefinite_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (invalid_o && $past(inv_mask_i)) |->
      (result_o == ($past(mode64_i && size64_i) ? WIDE_MIN : NAR_MIN)));

  assert_unmasked_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (invalid_o && !$past(inv_mask_i)) |-> (result_o == $past(result_o)));

  assert_narrow_upper_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(mode64_i && size64_i) && !(invalid_o && !$past(inv_mask_i))) |->
      (result_o[INT_W-1:NAR_W] == '0));
endmodule

bind f2i_convert f2i_convert_chk #(
  .SRC_W(SRC_W), .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W), .NAR_W(NAR_W)
) u_chk (.*);

// File: tb/sim_f2i_convert.sv
`timescale 1ns/1ps
module sim_f2i_convert;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src = '0;
  logic        size64 = 1'b0, mode64 = 1'b0, ovr_en = 1'b0, src_reg = 1'b0, mask = 1'b1;
  logic [1:0]  rc_g = '0, rc_o = '0;
  logic [63:0] result;
  logic        inv, prec;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [63:0] exp_res, prev_res;
  logic        exp_inv, exp_prec;

  always #5 clk = ~clk;

  f2i_convert u0 (
    .clk_i(clk), .rst_i(rst), .src_i(src), .size64_i(size64), .mode64_i(mode64),
    .rc_global_i(rc_g), .rc_ovr_i(rc_o), .rc_ovr_en_i(ovr_en), .src_reg_i(src_reg),
    .inv_mask_i(mask), .result_o(result), .invalid_o(inv), .precision_o(prec));

  function automatic logic [22:0] frac_pat(input int i);
    case (i)
      0: return 23'h000000;
      1: return 23'h000001;
      2: return 23'h400000;
      3: return 23'h400001;
      4: return 23'h7FFFFF;
      5: return 23'h000003;
      6: return 23'h200000;
      default: return 23'h600000;
    endcase
  endfunction

  // Reference: exact real arithmetic on the operand value.
  task automatic model(input logic [31:0] fp, input logic [1:0] rm, input logic wide,
                       input logic msk);
    int   e, ue;
    real  m, sv, fl, r, lim;
    longint li;
    e = int'(fp[30:23]);
    if (e == 255) begin
      exp_inv = 1'b1; exp_prec = 1'b0;
    end else begin
      m  = (e != 0) ? real'(fp[22:0]) + 8388608.0 : real'(fp[22:0]);
      ue = ((e != 0) ? e : 1) - 127;
      sv = m * (2.0 ** (ue - 23));
      if (fp[31]) sv = -sv;
      case (rm)
        2'b00: begin
          fl = $floor(sv);
          if (sv - fl > 0.5) r = fl + 1.0;
          else if (sv - fl < 0.5) r = fl;
          else r = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
        end
        2'b01: r = $floor(sv);
        2'b10: r = $ceil(sv);
        default: r = (sv < 0.0) ? $ceil(sv) : $floor(sv);
      endcase
      lim = wide ? 2.0 ** 63 : 2.0 ** 31;
      exp_inv  = !(r >= -lim && r < lim);
      exp_prec = !exp_inv && (r != sv);
      if (!exp_inv) begin
        li = longint'(r);
        exp_res = wide ? li : {32'h0, li[31:0]};
      end
    end
    if (exp_inv) exp_res = msk ? (wide ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000)
                               : prev_res;
    prev_res = exp_res;
  endtask

  task automatic compare(input string tag);
    tests++;
    if (result !== exp_res || inv !== exp_inv || prec !== exp_prec) begin
      fails++;
      $display("FAIL %s src=%h res=%h inv=%0b prec=%0b expected res=%h inv=%0b prec=%0b",
               tag, src[31:0], result, inv, prec, exp_res, exp_inv, exp_prec);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    string tag;
    logic [1:0] rm;
    prev_res = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    exp_res = '0; exp_inv = 1'b0; exp_prec = 1'b0;
    compare("R10 reset");
    rst = 1'b0;

    // Sweep: R1 random upper bits, R2 widths, R3 modes, R4 mode source, R5..R9, R11
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int e = 0; e < 256; e++) begin
        for (int mi = 0; mi < 8; mi++) begin
          for (int s = 0; s < 2; s++) begin
            for (int rmi = 0; rmi < 4; rmi++) begin
              int path;
              rm     = 2'(rmi);
              mode64 = cfg[1];
              size64 = cfg[0];
              mask   = ((e + mi + rmi) % 5) != 0;
              src    = {$urandom(), 1'(s), 8'(e), frac_pat(mi)};
              path   = (e + mi + s) % 3;
              if (path == 0) begin
                rc_g = rm; ovr_en = 1'b0; src_reg = 1'($urandom()); rc_o = ~rm;
              end else if (path == 1) begin
                rc_o = rm; ovr_en = 1'b1; src_reg = 1'b1; rc_g = ~rm;
              end else begin
                rc_g = rm; ovr_en = 1'b1; src_reg = 1'b0; rc_o = ~rm;
              end
              model(src[31:0], rm, mode64 & size64, mask);
              @(negedge clk);
              if (e == 255) tag = "R8";
              else if (exp_inv && !mask) tag = "R7 R5";
              else if (exp_inv) tag = "R6 R5";
              else if (exp_prec) tag = (path == 0) ? "R9 R3" : "R4 R3 R9";
              else tag = (mode64 & size64) ? "R3 R1" : "R2 R1";
              compare(tag);
              tests++;
              if (inv && prec) begin
                fails++;
                $display("FAIL R11 inv=%0b prec=%0b expected not both", inv, prec);
              end
            end
          end
        end
      end
    end

    // R5 bounds: -2^31 valid, +2^31 invalid in 32 bits; -2^63 valid in 64 bits
    mask = 1'b1; ovr_en = 1'b0; rc_g = 2'b11;
    mode64 = 1'b0; size64 = 1'b0; src = {32'h0, 32'hCF00_0000};
    model(src[31:0], 2'b11, 1'b0, 1'b1); @(negedge clk); compare("R5 neg bound 32");
    src = {32'h0, 32'h4F00_0000};
    model(src[31:0], 2'b11, 1'b0, 1'b1); @(negedge clk); compare("R5 pos bound 32");
    mode64 = 1'b1; size64 = 1'b1; src = {32'h0, 32'hDF00_0000};
    model(src[31:0], 2'b11, 1'b1, 1'b1); @(negedge clk); compare("R5 neg bound 64");

    // R1: upper source bits all ones vs zeros, same low word 1.5 nearest-even -> 2
    rc_g = 2'b00; src = {32'hFFFF_FFFF, 32'h3FC0_0000};
    model(src[31:0], 2'b00, 1'b1, 1'b1); @(negedge clk); compare("R1 upper ones");
    src = {32'h0, 32'h3FC0_0000};
    model(src[31:0], 2'b00, 1'b1, 1'b1); @(negedge clk); compare("R1 upper zeros");

    // R10: mid-run reset clears outputs
    rst = 1'b1; @(negedge clk);
    exp_res = '0; exp_inv = 1'b0; exp_prec = 1'b0; prev_res = '0;
    compare("R10 reset mid-run");
    rst = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule